// File: doc/BRIEF.md
# Multi-Channel Edge Capture Unit

This block timestamps edges on five external inputs against one shared free-running 16-bit timebase. Each input is synchronized and filtered, so a level is only accepted after it has held for two consecutive clocks. When a channel sees an accepted edge of the kind it is set up for, the current timebase value is copied into that channel's own 16-bit capture register. Software reads that register as a low byte and a high byte.

Every channel has a rising-edge bit, a falling-edge bit and an interrupt-enable bit. With both edge bits set, a channel captures on either transition. Software then reads the filtered input levels to learn which edge it was. A capture sets a sticky per-channel flag, and the flags with their enables drive one shared interrupt line. Flags are cleared only by software writing a 0 to them. The timebase runs while a run bit is set and raises its own sticky overflow flag when it wraps.

Top module: `edgecap_unit`

Register map (5-bit address, 8-bit data):

| Address | Name | Bits |
|---|---|---|
| 0x00 | control | [0] run (read/write); [1] overflow flag (read; writing 0 clears it) |
| 0x01 | flags | [4:0] channel flags (read; writing 0 to a bit clears it, writing 1 has no effect) |
| 0x02 | levels | [4:0] filtered input levels (read only) |
| 0x03 / 0x04 | timebase | low byte / high byte (read only) |
| 0x08+ch | mode | [0] rising, [1] falling, [2] interrupt enable (read/write) |
| 0x10+2·ch / 0x11+2·ch | capture | low byte / high byte (read only) |

## Requirements
- R1: After reset, the timebase, the run bit, the overflow flag, all channel flags, all mode registers and all capture registers read 0, and irq is 0.
- R2: While run (control bit 0) is 1, the timebase (addresses 0x03/0x04) increases by one every clock. While run is 0, the timebase holds its value.
- R3: When the timebase steps from 0xFFFF to 0x0000, the overflow flag (control bit 1) becomes 1. It stays 1 until software writes control with bit 1 at 0. Writing bit 1 as 1 leaves it set.
- R4: A channel with only the rising bit (mode bit 0) set captures on a low-to-high input change and ignores a high-to-low change.
- R5: A channel with only the falling bit (mode bit 1) set captures on a high-to-low input change and ignores a low-to-high change.
- R6: A channel with both edge bits set captures on either transition.
- R7: A channel with both edge bits 0 never captures. Its flag and its capture register are left unchanged by input activity.
- R8: An input level is accepted only after it has been seen for two consecutive clocks after the two-flop synchronizer. A one-clock pulse is ignored. The value captured equals the timebase value read in the clock in which the input changed, plus 3.
- R9: A capture sets the channel's flag in the flags register (bit = channel number). The flag stays 1 until software writes a 0 to that bit. Writing a 1 to it has no effect.
- R10: When a capture and a software clear of the same flag occur in the same clock, the flag ends up 1. A clear of a different flag in the same write still takes effect.
- R11: irq is 1 exactly when some channel has its flag set and its interrupt-enable bit (mode bit 2) set.
- R12: The levels register (0x02) shows each channel's filtered input level, with bit = channel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_in | input | 5 | External capture inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 1 | Shared capture interrupt request |

## Verification
A hardware capture and a software flag clear can both act on one channel's flag in the same clock. The bench provokes this by counting the fixed input-to-capture latency. It drives the input and then asserts a write of zeros to the flags register exactly in the clock where the capture lands. The flag of the capturing channel must read 1 afterwards. Another channel's flag, set earlier and cleared by the same write, must read 0. The captured value is also compared against the timebase read when the input changed, plus 3.

// File: rtl/edgecap_pkg.sv
package edgecap_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL      = 5'h00;
  localparam logic [ADDR_W-1:0] A_FLAGS     = 5'h01;
  localparam logic [ADDR_W-1:0] A_LEVELS    = 5'h02;
  localparam logic [ADDR_W-1:0] A_CNT_LO    = 5'h03;
  localparam logic [ADDR_W-1:0] A_CNT_HI    = 5'h04;
  localparam int unsigned       A_MODE_BASE = 8;
  localparam int unsigned       A_CAP_BASE  = 16;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_OVF_BIT = 1;

  typedef struct packed {
    logic ie;
    logic fall;
    logic rise;
  } chan_mode_t;
endpackage

// File: rtl/edgecap_timebase.sv
module edgecap_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q, count_nxt;
  logic             ovf_q, ovf_nxt;
  logic             wrap;

  always_comb begin
    wrap      = run && (count_q == CNT_MAX);
    count_nxt = count_q;
    if (run) count_nxt = count_q + CNT_W'(1);
    ovf_nxt   = wrap | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      count_q <= count_nxt;
      ovf_q   <= ovf_nxt;
    end
  end

  assign count = count_q;
  assign ovf   = ovf_q;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && ($past(count_q) != CNT_MAX)) |-> (count_q == $past(count_q) + CNT_W'(1)));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> $stable(count_q));
  assert_ovf_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && ($past(count_q) == CNT_MAX)) |-> (ovf_q && count_q == '0));
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovf_q) && !$past(ovf_clr)) |-> ovf_q);
endmodule

// File: rtl/edgecap_qualifier.sv
module edgecap_qualifier (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise_evt,
  output logic fall_evt
);
  logic sync1_q, sync2_q, hist_q, level_q;
  logic level_nxt, accept;

  always_comb begin
    accept    = (sync2_q != level_q) && (hist_q == sync2_q);
    level_nxt = accept ? sync2_q : level_q;
    rise_evt  = accept &  sync2_q;
    fall_evt  = accept & ~sync2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      hist_q  <= 1'b0;
      level_q <= 1'b0;
    end else begin
      sync1_q <= pin;
      sync2_q <= sync1_q;
      hist_q  <= sync2_q;
      level_q <= level_nxt;
    end
  end

  assign level = level_q;

  assert_filter_two_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(sync2_q) == level_q && $past(hist_q) == level_q));
  assert_single_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));
endmodule

// File: rtl/edgecap_channel.sv
module edgecap_channel
  import edgecap_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_mode_t       mode,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic [CNT_W-1:0] count,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap_val,
  output logic             flag
);
  logic [CNT_W-1:0] cap_q, cap_nxt;
  logic             flag_q, flag_nxt;
  logic             cap_evt;

  always_comb begin
    cap_evt  = (mode.rise & rise_evt) | (mode.fall & fall_evt);
    cap_nxt  = cap_evt ? count : cap_q;
    flag_nxt = cap_evt | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cap_q  <= cap_nxt;
      flag_q <= flag_nxt;
    end
  end

  assign cap_val = cap_q;
  assign flag    = flag_q;

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode.rise || mode.fall) |-> ($stable(cap_q) && !$rose(flag_q)));
  assert_flag_on_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_evt) |-> (flag_q && cap_q == $past(count)));
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q) && !$past(flag_clr)) |-> flag_q);
  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_evt && flag_clr) |-> flag_q);
  assert_rise_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fall_evt && !mode.fall) |-> $stable(cap_q));
  assert_fall_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rise_evt && !mode.rise) |-> $stable(cap_q));
endmodule

// File: rtl/edgecap_unit.sv
module edgecap_unit
  import edgecap_pkg::*;
#(
  parameter int unsigned N_CH  = 5,
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   ext_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  // Channel count is limited to 8 by the byte-wide flag/level registers
  // and by the address space of the capture window.
  localparam int unsigned MODE_W = $bits(chan_mode_t);

  // reset: asynchronous assert, synchronous release
  logic rst_q1, rst_q2, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign rst_sync_n = rst_q2;

  // control register
  logic run_q, run_nxt, ctrl_wr, ovf_clr, ovf;
  logic [CNT_W-1:0] count;

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == A_CTRL);
    run_nxt = ctrl_wr ? wr_data[CTRL_RUN_BIT] : run_q;
    ovf_clr = ctrl_wr && !wr_data[CTRL_OVF_BIT];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) run_q <= 1'b0;
    else             run_q <= run_nxt;
  end

  edgecap_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (run_q),
    .ovf_clr (ovf_clr),
    .count   (count),
    .ovf     (ovf)
  );

  // per-channel logic
  chan_mode_t       mode_q [N_CH];
  logic [CNT_W-1:0] cap_val [N_CH];
  logic [N_CH-1:0]  flags, levels, ie_vec, flag_clr;
  logic             flags_wr;

  assign flags_wr = wr_en && (wr_addr == A_FLAGS);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(A_MODE_BASE + g);
    chan_mode_t mode_nxt;
    logic       rise_evt, fall_evt;

    always_comb begin
      mode_nxt = mode_q[g];
      if (wr_en && (wr_addr == MODE_ADDR)) mode_nxt = chan_mode_t'(wr_data[MODE_W-1:0]);
      flag_clr[g] = flags_wr && !wr_data[g];
      ie_vec[g]   = mode_q[g].ie;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) mode_q[g] <= '0;
      else             mode_q[g] <= mode_nxt;
    end

    edgecap_qualifier u_qual (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .pin      (ext_in[g]),
      .level    (levels[g]),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
    );

    edgecap_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .mode     (mode_q[g]),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt),
      .count    (count),
      .flag_clr (flag_clr[g]),
      .cap_val  (cap_val[g]),
      .flag     (flags[g])
    );
  end

  assign irq = |(flags & ie_vec);

  // read mux
  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL:   rd_data = DATA_W'({ovf, run_q});
      A_FLAGS:  rd_data = DATA_W'(flags);
      A_LEVELS: rd_data = DATA_W'(levels);
      A_CNT_LO: rd_data = count[7:0];
      A_CNT_HI: rd_data = DATA_W'(count >> 8);
      default:  rd_data = '0;
    endcase
    for (int i = 0; i < N_CH; i++) begin
      if (rd_addr == ADDR_W'(A_MODE_BASE + i))       rd_data = DATA_W'(mode_q[i]);
      if (rd_addr == ADDR_W'(A_CAP_BASE + 2*i))      rd_data = cap_val[i][7:0];
      if (rd_addr == ADDR_W'(A_CAP_BASE + 2*i + 1))  rd_data = DATA_W'(cap_val[i] >> 8);
    end
  end

  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (|flags));
  assert_irq_follows_enable_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ie_vec == '0) |-> !irq);
  assert_run_write_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(ctrl_wr) |-> (run_q == $past(wr_data[CTRL_RUN_BIT])));
endmodule

// File: tb/edgecap_unit_bench.sv
module edgecap_unit_bench;
  localparam int CLK_P = 10;
  localparam int N_CH  = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N_CH-1:0] ext_in;
  logic            wr_en;
  logic [4:0]      wr_addr, rd_addr;
  logic [7:0]      wr_data, rd_data;
  logic            irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  edgecap_unit #(.N_CH(N_CH), .CNT_W(16)) u_edgecap_unit (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // vector: {ch[2:0], mode[1:0] (bit0 rise, bit1 fall), level, expect_capture}
  localparam logic [6:0] VEC [10] = '{
    {3'd0, 2'b01, 1'b1, 1'b1},
    {3'd0, 2'b01, 1'b0, 1'b0},
    {3'd1, 2'b10, 1'b1, 1'b0},
    {3'd1, 2'b10, 1'b0, 1'b1},
    {3'd2, 2'b11, 1'b1, 1'b1},
    {3'd2, 2'b11, 1'b0, 1'b1},
    {3'd3, 2'b00, 1'b1, 1'b0},
    {3'd3, 2'b00, 1'b0, 1'b0},
    {3'd4, 2'b11, 1'b1, 1'b1},
    {3'd4, 2'b01, 1'b0, 1'b0}
  };

  logic [15:0] exp_cap [N_CH];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic rd16(input logic [4:0] a_lo, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a_lo, lo);
    rd(a_lo + 5'd1, hi);
    v = {hi, lo};
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b01:   return "R4";
      2'b10:   return "R5";
      2'b11:   return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] c, v;
    rst_n = 1'b0; ext_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    for (int i = 0; i < N_CH; i++) exp_cap[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(5'h00, d); chk("R1 ctrl", d, 8'h00);
    rd(5'h01, d); chk("R1 flags", d, 8'h00);
    rd16(5'h03, v); chk("R1 timebase", v, 16'h0);
    rd(5'h0A, d); chk("R1 mode2", d, 8'h00);
    rd16(5'h18, v); chk("R1 capture4", v, 16'h0);
    chk("R1 irq", irq, 1'b0);

    // R2 hold while stopped, then run
    repeat (5) @(negedge clk);
    rd16(5'h03, v); chk("R2 hold stopped", v, 16'h0);
    wr(5'h00, 8'h01);
    rd16(5'h03, c);
    repeat (10) @(negedge clk);
    rd16(5'h03, v); chk("R2 increment", v, c + 16'd10);

    // vector table walk
    for (int i = 0; i < 10; i++) begin
      logic [2:0] ch;
      logic [1:0] md;
      logic       lv, ex;
      {ch, md, lv, ex} = VEC[i];
      wr(5'(8 + ch), {5'b0, 1'b1, md});
      wr(5'h01, 8'h00);
      ext_in[ch] = lv;
      rd16(5'h03, c);
      repeat (5) @(negedge clk);
      if (ex) exp_cap[ch] = c + 16'd3;
      rd(5'h01, d); chk({mode_tag(md), " R9 flag"}, d[ch], ex);
      rd16(5'(16 + 2*ch), v); chk({mode_tag(md), " R8 capture"}, v, exp_cap[ch]);
      rd(5'h02, d); chk("R12 level", d[ch], lv);
      if (ex) chk("R11 irq on capture", irq, 1'b1);
    end

    // R8 one-clock pulse ignored, two-clock pulse accepted (ch0, both edges)
    wr(5'h08, 8'h07);
    wr(5'h01, 8'h00);
    ext_in[0] = 1'b1; @(negedge clk); ext_in[0] = 1'b0;
    repeat (6) @(negedge clk);
    rd(5'h01, d); chk("R8 glitch flag", d[0], 1'b0);
    rd16(5'h10, v); chk("R8 glitch capture", v, exp_cap[0]);
    rd(5'h02, d); chk("R8 glitch level", d[0], 1'b0);
    ext_in[0] = 1'b1; @(negedge clk); @(negedge clk); ext_in[0] = 1'b0;
    rd16(5'h03, c);
    repeat (6) @(negedge clk);
    rd(5'h01, d); chk("R8 pulse flag", d[0], 1'b1);
    rd16(5'h10, v); chk("R8 pulse capture", v, c + 16'd3);

    // R10 capture and clear in the same clock
    wr(5'h01, 8'h00);
    ext_in[2] = 1'b1;
    repeat (5) @(negedge clk);
    wr(5'h09, 8'h07);
    ext_in[1] = 1'b1;
    rd16(5'h03, c);
    repeat (3) @(negedge clk);
    wr(5'h01, 8'h00);
    repeat (2) @(negedge clk);
    rd(5'h01, d);
    chk("R10 set wins", d[1], 1'b1);
    chk("R9 other flag cleared", d[2], 1'b0);
    rd16(5'h12, v); chk("R10 capture", v, c + 16'd3);

    // R9 writing 1 leaves flag set, writing 0 clears
    wr(5'h01, 8'hFF);
    rd(5'h01, d); chk("R9 write one keeps", d[1], 1'b1);

    // R11 enable gates interrupt
    chk("R11 irq enabled", irq, 1'b1);
    wr(5'h09, 8'h03);
    chk("R11 irq disabled", irq, 1'b0);
    wr(5'h01, 8'hFD);
    rd(5'h01, d); chk("R9 write zero clears", d[1], 1'b0);

    // R3 wrap and sticky overflow
    wr(5'h00, 8'h01);
    rd(5'h00, d); chk("R3 ovf clear", d[1], 1'b0);
    for (int k = 0; k < 70000; k++) begin
      rd16(5'h03, v);
      if (v == 16'hFFFF) break;
      @(negedge clk);
    end
    chk("R3 reached top", v, 16'hFFFF);
    rd(5'h00, d); chk("R3 ovf before wrap", d[1], 1'b0);
    @(negedge clk);
    rd16(5'h03, v); chk("R3 wrapped", v, 16'h0);
    rd(5'h00, d); chk("R3 ovf set", d[1], 1'b1);
    wr(5'h00, 8'h03);
    rd(5'h00, d); chk("R3 ovf kept by one", d[1], 1'b1);
    wr(5'h00, 8'h01);
    rd(5'h00, d); chk("R3 ovf cleared", d[1], 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule